// File: doc/BRIEF.md
# Internal Data Memory Space Decoder

This block resolves every internal data access of a small 8-bit controller core. An access carries an 8-bit address, a write flag and an addressing-mode flag that marks it as direct or indirect. The decoder steers the access to one of three places: the lower 128-byte RAM, the upper 128-byte RAM, or a special function register (SFR) bus that feeds SFR logic outside this block. Both RAM halves are inside the block.

The address range 80h-FFh is shared by two separate stores. The addressing mode alone picks between them. An indirect access lands in the upper RAM, and a direct access goes out on the SFR bus. Addresses below 80h reach the lower RAM in either mode. Stack accesses are flagged separately and are always decoded as indirect. As a result, a stack push or pop always stays in the 256 bytes of internal RAM and never touches an SFR.

Read data comes back registered, one clock after the request. A write commits on the same clock edge that accepts the request.

Top module: `idm_space_dec`

## Requirements
- R1: An access to an address in 00h-7Fh selects the lower RAM (`sel_lo_o`), whether it is direct or indirect.
- R2: An indirect access to 80h-FFh selects the upper RAM (`sel_hi_o`).
- R3: A direct access to 80h-FFh selects the SFR bus (`sel_sfr_o`). On a write it pulses `sfr_we_o`, and it never reads or writes the upper RAM.
- R4: The upper RAM and the SFR space are separate stores. A direct write to address A leaves the upper RAM byte at A unchanged. An indirect write to A never asserts `sfr_we_o`.
- R5: An access with `stack_i`=1 is decoded as indirect, whatever the value of `indirect_i`.
- R6: `rdata_o` updates only on the clock edge that accepts a read (`req_i`=1, `we_i`=0). It holds its value through idle cycles and write cycles.
- R7: A direct read of an SFR address where `sfr_ack_i`=0 returns 00h.
- R8: While `req_i`=1, exactly one of `sel_lo_o`, `sel_hi_o`, `sel_sfr_o` is high. While `req_i`=0, all three are low.
- R9: After reset, `rdata_o` is 00h.
- R10: A write commits on its request edge, so a read of the same address in the very next cycle returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| indirect_i | input | 1 | 1 = indirect addressing, 0 = direct |
| stack_i | input | 1 | Stack access, always decoded as indirect |
| addr_i | input | ADDR_W | Internal data address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| sel_lo_o | output | 1 | Lower RAM target strobe |
| sel_hi_o | output | 1 | Upper RAM target strobe |
| sel_sfr_o | output | 1 | SFR target strobe, also the SFR read/write request |
| sfr_addr_o | output | ADDR_W | SFR bus address |
| sfr_wdata_o | output | DATA_W | SFR bus write data |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_rdata_i | input | DATA_W | SFR read data, valid in the request cycle |
| sfr_ack_i | input | 1 | An SFR exists at `sfr_addr_o` |

## Verification
The hardest case to reach is the aliasing between the two stores that share 80h-FFh. A defect here shows up only when the same address is written through both paths and then read back through both paths. To reach it, the stimulus writes different bytes to 90h, first indirectly and then directly. It then reads 90h both ways, and each read must return its own byte. The stack flag is exercised the same way: a stack write is issued with the direct flag set, and the byte is then read back indirectly from the upper RAM.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2,
    TGT_SFR  = 2'd3
  } idm_tgt_e;
endpackage

// File: rtl/idm_addr_decode.sv
module idm_addr_decode
  import idm_pkg::*;
(
  input  logic     req_i,
  input  logic     addr_msb_i,
  input  logic     indirect_i,
  input  logic     stack_i,
  output idm_tgt_e tgt_o,
  output logic     sel_lo_o,
  output logic     sel_hi_o,
  output logic     sel_sfr_o
);
  logic eff_ind;
  assign eff_ind = indirect_i | stack_i;  // stack is always indirect

  always_comb begin
    if (!req_i)          tgt_o = TGT_NONE;
    else if (!addr_msb_i) tgt_o = TGT_LO;
    else if (eff_ind)    tgt_o = TGT_HI;
    else                 tgt_o = TGT_SFR;
  end

  assign sel_lo_o  = (tgt_o == TGT_LO);
  assign sel_hi_o  = (tgt_o == TGT_HI);
  assign sel_sfr_o = (tgt_o == TGT_SFR);
endmodule

// File: rtl/idm_ram_bank.sv
module idm_ram_bank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/idm_space_dec.sv
module idm_space_dec
  import idm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              indirect_i,
  input  logic              stack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_lo_o,
  output logic              sel_hi_o,
  output logic              sel_sfr_o,
  output logic [ADDR_W-1:0] sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  output logic              sfr_we_o,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  input  logic              sfr_ack_i
);
  localparam int BANK_AW = ADDR_W - 1;
  localparam int NBANK   = 2;

  idm_tgt_e    tgt;
  logic [NBANK-1:0] bank_sel;
  logic [DATA_W-1:0] bank_rd [NBANK];

  idm_addr_decode u_dec (
    .req_i      (req_i),
    .addr_msb_i (addr_i[ADDR_W-1]),
    .indirect_i (indirect_i),
    .stack_i    (stack_i),
    .tgt_o      (tgt),
    .sel_lo_o   (sel_lo_o),
    .sel_hi_o   (sel_hi_o),
    .sel_sfr_o  (sel_sfr_o)
  );

  assign bank_sel = {sel_hi_o, sel_lo_o};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    idm_ram_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_sel[b] & we_i),
      .addr_i  (addr_i[BANK_AW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[b])
    );
  end

  assign sfr_addr_o  = addr_i;
  assign sfr_wdata_o = wdata_i;
  assign sfr_we_o    = sel_sfr_o & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (req_i && !we_i) begin
      unique case (tgt)
        TGT_LO:  rdata_o <= bank_rd[0];
        TGT_HI:  rdata_o <= bank_rd[1];
        TGT_SFR: rdata_o <= sfr_ack_i ? sfr_rdata_i : '0;  // unimplemented SFR reads 0
        default: rdata_o <= rdata_o;
      endcase
    end
  end
endmodule

// File: rtl/idm_space_dec_chk.sv
module idm_space_dec_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              indirect_i,
  input logic              stack_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sel_lo_o,
  input logic              sel_hi_o,
  input logic              sel_sfr_o,
  input logic              sfr_we_o,
  input logic              sfr_ack_i
);
  // R8
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $countones({sel_lo_o, sel_hi_o, sel_sfr_o}) == 1);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(sel_lo_o || sel_hi_o || sel_sfr_o));
  // R1
  low_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_i[ADDR_W-1]) |-> sel_lo_o);
  // R2
  upper_ind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1] && indirect_i) |-> sel_hi_o);
  // R3
  sfr_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_sfr_o |-> (addr_i[ADDR_W-1] && !indirect_i && !stack_i));
  // R5
  stack_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && stack_i) |-> !sel_sfr_o);
  // R4
  no_sfr_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi_o |-> !sfr_we_o);
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |=> $stable(rdata_o));
  // R7
  sfr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_sfr_o && !we_i && !sfr_ack_i) |=> rdata_o == '0);
endmodule

bind idm_space_dec idm_space_dec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .indirect_i(indirect_i), .stack_i(stack_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .sel_lo_o(sel_lo_o), .sel_hi_o(sel_hi_o),
  .sel_sfr_o(sel_sfr_o), .sfr_we_o(sfr_we_o), .sfr_ack_i(sfr_ack_i)
);

// File: tb/idm_space_dec_tb_top.sv
`timescale 1ns/1ps
module idm_space_dec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, ind = 1'b0, stk = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic       sel_lo, sel_hi, sel_sfr, sfr_we, sfr_ack;
  logic [7:0] sfr90;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  idm_space_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .indirect_i(ind),
    .stack_i(stk), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sel_lo_o(sel_lo), .sel_hi_o(sel_hi), .sel_sfr_o(sel_sfr),
    .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata), .sfr_we_o(sfr_we),
    .sfr_rdata_i(sfr_rdata), .sfr_ack_i(sfr_ack)
  );

  // bench SFR model: one register at 90h
  assign sfr_ack   = (sfr_addr == 8'h90);
  assign sfr_rdata = sfr90;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sfr90 <= 8'h00;
    else if (sfr_we && sfr_addr == 8'h90) sfr90 <= sfr_wdata;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // {we, ind, stk, addr, wdata, sel{lo,hi,sfr}, exp_rdata}
  localparam logic [29:0] VEC [16] = '{
    {3'b100, 8'h10, 8'hA1, 3'b100, 8'h00},
    {3'b110, 8'h90, 8'h5C, 3'b010, 8'h00},
    {3'b100, 8'h90, 8'h3E, 3'b001, 8'h00},
    {3'b010, 8'h10, 8'h00, 3'b100, 8'hA1},
    {3'b000, 8'h10, 8'h00, 3'b100, 8'hA1},
    {3'b010, 8'h90, 8'h00, 3'b010, 8'h5C},  // R4 upper RAM kept
    {3'b000, 8'h90, 8'h00, 3'b001, 8'h3E},  // R4 SFR kept
    {3'b000, 8'hA5, 8'h00, 3'b001, 8'h00},  // R7 empty SFR
    {3'b101, 8'hC0, 8'h77, 3'b010, 8'h00},  // R5 stack write, direct flag
    {3'b010, 8'hC0, 8'h00, 3'b010, 8'h77},  // R5 readback
    {3'b110, 8'h7F, 8'h12, 3'b100, 8'h00},
    {3'b000, 8'h7F, 8'h00, 3'b100, 8'h12},
    {3'b110, 8'h80, 8'h34, 3'b010, 8'h00},
    {3'b001, 8'h80, 8'h00, 3'b010, 8'h34},  // R5 stack read
    {3'b110, 8'hFF, 8'h9A, 3'b010, 8'h00},
    {3'b010, 8'hFF, 8'h00, 3'b010, 8'h9A}
  };

  function automatic string tag_of(input logic [2:0] s);
    return s[2] ? "R1" : (s[1] ? "R2" : "R3");
  endfunction

  task automatic access(input logic w, input logic i, input logic s,
                        input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; ind = i; stk = s; addr = a; wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0; ind = 1'b0; stk = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9", rdata, 8'h00);
    check("R8", {5'b0, sel_lo, sel_hi, sel_sfr}, 8'h00);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) begin
      access(VEC[k][29], VEC[k][28], VEC[k][27], VEC[k][26:19], VEC[k][18:11]);
      #1;
      check({tag_of(VEC[k][10:8]), " R8 sel"}, {5'b0, sel_lo, sel_hi, sel_sfr},
            {5'b0, VEC[k][10:8]});
      if (VEC[k][10:8] == 3'b010) check("R4 sfr_we", {7'b0, sfr_we}, 8'h00);
      if (VEC[k][10:8] == 3'b001) check("R3 sfr_we", {7'b0, sfr_we}, {7'b0, VEC[k][29]});
      idle();
      if (!VEC[k][29]) check({tag_of(VEC[k][10:8]), " rdata"}, rdata, VEC[k][7:0]);
    end

    // R6 hold across idle and write
    held = rdata;
    idle();
    check("R6 idle", rdata, held);
    access(1'b1, 1'b1, 1'b0, 8'h20, 8'h66);
    idle();
    check("R6 write", rdata, held);

    // R10 write then immediate read
    access(1'b1, 1'b0, 1'b0, 8'h21, 8'hC3);
    access(1'b0, 1'b1, 1'b0, 8'h21, 8'h00);
    idle();
    check("R10", rdata, 8'hC3);

    // R4 direct write to upper address leaves upper RAM alone
    access(1'b1, 1'b1, 1'b0, 8'hB0, 8'h11);
    access(1'b1, 1'b0, 1'b0, 8'hB0, 8'hEE);
    access(1'b0, 1'b1, 1'b0, 8'hB0, 8'h00);
    idle();
    check("R4 aliasing", rdata, 8'h11);

    // R7 empty SFR after a non-zero read
    access(1'b0, 1'b0, 1'b0, 8'h90, 8'h00);
    access(1'b0, 1'b0, 1'b0, 8'hF0, 8'h00);
    #1;
    check("R7 pre", rdata, 8'h3E);
    idle();
    check("R7", rdata, 8'h00);

    // R8 idle quiet
    #1;
    check("R8 idle", {5'b0, sel_lo, sel_hi, sel_sfr}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule